// File: doc/BRIEF.md
# Three-Port Layer-2 Forwarding Decision Unit

This unit picks the egress ports for every frame that enters a three-port Layer-2 switch. The receive path hands over a parsed header in one strobe: destination MAC, source MAC, an optional 802.1Q VLAN ID and the ingress port number. Exactly four clock cycles later the unit returns a three-bit egress port mask, a flood flag and a drop flag. Frame data, buffering, MAC interfaces and pause handling are all outside this block.

The unit learns. The source address of each accepted header is stored in a small address table together with its port. The destination address is then looked up in that table. The result of the lookup, or a flood set when the lookup cannot resolve one port, goes through two filters held in write-only configuration registers. The first is a VLAN membership rule keyed on the VLAN ID and the ingress port. The second is a directional port-to-port permission matrix. This matrix can let traffic go from port A to port B while blocking traffic from B to A.

Top module: `l2_fwd_decide`

## Requirements
- R1: A header strobed on `hdr_valid` in cycle n gives `res_valid` high for exactly cycle n+4. Back-to-back strobes give back-to-back results. While `res_valid` is low, `res_mask`, `res_flood` and `res_drop` are all 0.
- R2: For ingress ports 0..2, the source MAC of every header is stored with its ingress port, unless the source has its group bit set. If the address is already present, only its port is updated. Any header strobed after this one, even in the next cycle, sees the new mapping.
- R3: A destination with the group bit clear that is found in the table gives `res_flood`=0. The base mask is then the one-hot bit of the learned port (bit p stands for port p).
- R4: A destination whose group bit is set gives `res_flood`=1. The group bit is bit 40 of the 48-bit MAC, the LSB of the first octet, so broadcast is included. A destination not found in the table also gives `res_flood`=1. In both cases the base mask is every port except the ingress port.
- R5: The ingress port's bit is never set in `res_mask`. A destination learned on the ingress port itself gives an empty mask.
- R6: There are `NUM_RULES` VLAN rules at config addresses 0..NUM_RULES-1. Each rule has these fields: bit 15 enable, bits 14:12 member ports, bits 11:0 VLAN ID. The lowest-numbered enabled rule whose VLAN ID matches is applied. If the ingress port is not a member, the mask is empty; otherwise the mask is ANDed with the members. If no rule matches, the VLAN filter places no restriction.
- R7: Tagged headers use `hdr_vid`. Untagged headers use the default VLAN ID of their ingress port, held at config address 17+port. The reset value is 1.
- R8: The permission register is at config address 16, bits 8:0. Bit 3*src+dst allows traffic from port src to port dst. It resets to all ones. The mask is ANDed with the row of the ingress port.
- R9: `res_drop` is 1 exactly when a result's final mask is empty.
- R10: The table holds `NUM_ENTRIES` addresses. A new address goes into the slot named by a round-robin pointer. The pointer advances only on such an insertion, so the oldest insertion is evicted first.
- R11: Ingress code 3 is not a port. The header gets an empty mask and `res_drop`=1, and its source is not learned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header strobe, one cycle per frame |
| hdr_dst_mac | input | 48 | Destination MAC, first octet in bits 47:40 |
| hdr_src_mac | input | 48 | Source MAC, first octet in bits 47:40 |
| hdr_tagged | input | 1 | Header carries an 802.1Q tag |
| hdr_vid | input | 12 | VLAN ID from the tag |
| hdr_in_port | input | 2 | Ingress port number |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| res_valid | output | 1 | Result pulse |
| res_mask | output | 3 | Egress port mask |
| res_flood | output | 1 | Destination was group or unknown |
| res_drop | output | 1 | Final mask empty |

## Verification
The bench uses the default sizes: a 16-entry table, eight VLAN rules and a 5-bit configuration address. With these sizes, seventeen distinct source addresses are enough to wrap the round-robin pointer. That makes eviction of the first-learned address observable, while an address learned later stays resolvable. With the small rule count, a single enabled rule makes both the member and the non-member ingress cases reachable. The back-to-back strobe pair exercises the path where a lookup must see an address whose table write has not yet landed.

// File: rtl/l2fwd_pkg.sv
package l2fwd_pkg;
  localparam int MAC_W     = 48;
  localparam int VID_W     = 12;
  localparam int NPORT     = 3;
  localparam int PORT_W    = 2;
  localparam int GROUP_BIT = 40;
  localparam int CFG_DW    = 16;

  typedef logic [MAC_W-1:0]  mac_t;
  typedef logic [VID_W-1:0]  vid_t;
  typedef logic [NPORT-1:0]  pmask_t;
  typedef logic [PORT_W-1:0] port_t;

  function automatic pmask_t port_bit(input port_t p);
    pmask_t m;
    m = '0;
    for (int i = 0; i < NPORT; i++)
      if (p == PORT_W'(i)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/l2fwd_cfg_regs.sv
module l2fwd_cfg_regs
  import l2fwd_pkg::*;
#(
  parameter int NUM_RULES = 8,
  parameter int CFG_AW    = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [CFG_DW-1:0]         cfg_wdata,
  output logic                      rule_en  [NUM_RULES],
  output pmask_t                    rule_mem [NUM_RULES],
  output vid_t                      rule_vid [NUM_RULES],
  output logic [NPORT*NPORT-1:0]    perm,
  output vid_t                      dflt_vid [NPORT]
);
  localparam int PERM_ADDR = 2 ** (CFG_AW - 1);
  localparam int DVID_BASE = PERM_ADDR + 1;

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_rule
    always_ff @(posedge clk) begin
      if (rst) begin
        rule_en[i]  <= 1'b0;
        rule_mem[i] <= '0;
        rule_vid[i] <= '0;
      end else if (cfg_we && cfg_addr == CFG_AW'(i)) begin
        rule_en[i]  <= cfg_wdata[15];
        rule_mem[i] <= cfg_wdata[14:12];
        rule_vid[i] <= cfg_wdata[11:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) perm <= '1;
    else if (cfg_we && cfg_addr == CFG_AW'(PERM_ADDR))
      perm <= cfg_wdata[NPORT*NPORT-1:0];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_dvid
    always_ff @(posedge clk) begin
      if (rst) dflt_vid[p] <= VID_W'(1);
      else if (cfg_we && cfg_addr == CFG_AW'(DVID_BASE + p))
        dflt_vid[p] <= cfg_wdata[VID_W-1:0];
    end
  end
endmodule

// File: rtl/l2fwd_vlan_filter.sv
module l2fwd_vlan_filter
  import l2fwd_pkg::*;
#(
  parameter int NUM_RULES = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   in_valid,
  input  port_t  in_port,
  input  vid_t   in_vid,
  input  logic   rule_en  [NUM_RULES],
  input  pmask_t rule_mem [NUM_RULES],
  input  vid_t   rule_vid [NUM_RULES],
  output pmask_t rule_mask
);
  logic   hit;
  pmask_t mem;
  pmask_t mask_n;

  always_comb begin
    hit = 1'b0;
    mem = '1;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (rule_en[i] && rule_vid[i] == in_vid) begin
        hit = 1'b1;
        mem = rule_mem[i];
      end
    end
    if (!hit)                              mask_n = '1;
    else if ((mem & port_bit(in_port)) != '0) mask_n = mem;
    else                                   mask_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !in_valid) rule_mask <= '0;
    else                  rule_mask <= mask_n;
  end

  p_rule_subset_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && hit |=> (rule_mask & ~$past(mem)) == '0);
endmodule

// File: rtl/l2fwd_addr_table.sv
module l2fwd_addr_table
  import l2fwd_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  q_valid,
  input  mac_t  q_dst,
  input  mac_t  q_src,
  input  port_t q_port,
  input  logic  q_learn,
  output logic  r_hit,
  output port_t r_port
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic              ent_v    [ENTRIES];
  mac_t              ent_mac  [ENTRIES];
  port_t             ent_port [ENTRIES];
  logic [IDX_W-1:0]  rr_ptr;

  // pending learn write (stage after lookup)
  logic              l_en;
  mac_t              l_mac;
  port_t             l_port;
  logic              l_hit;
  logic [IDX_W-1:0]  l_idx;

  logic              w_en;
  logic [IDX_W-1:0]  w_idx;

  logic [ENTRIES-1:0] s_raw;
  logic               d_hit, s_hit, d_byp, s_byp;
  port_t              d_port;
  logic [IDX_W-1:0]   s_idx;

  assign w_en  = l_en;
  assign w_idx = l_hit ? l_idx : rr_ptr;
  assign d_byp = w_en && (l_mac == q_dst);
  assign s_byp = w_en && (l_mac == q_src);

  always_comb begin
    d_hit  = 1'b0;
    d_port = '0;
    s_hit  = 1'b0;
    s_idx  = '0;
    s_raw  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      s_raw[i] = ent_v[i] && (ent_mac[i] == q_src);
      if (!(w_en && !l_hit && w_idx == IDX_W'(i)) && ent_v[i]) begin
        if (ent_mac[i] == q_dst) begin
          d_hit  = 1'b1;
          d_port = ent_port[i];
        end
        if (ent_mac[i] == q_src) begin
          s_hit = 1'b1;
          s_idx = IDX_W'(i);
        end
      end
    end
  end

  // lookup result and learn request
  always_ff @(posedge clk) begin
    if (rst) begin
      r_hit  <= 1'b0;
      r_port <= '0;
      l_en   <= 1'b0;
      l_hit  <= 1'b0;
      l_idx  <= '0;
      l_mac  <= '0;
      l_port <= '0;
    end else begin
      r_hit  <= q_valid && (d_byp || d_hit);
      r_port <= d_byp ? l_port : d_port;
      l_en   <= q_valid && q_learn;
      l_mac  <= q_src;
      l_port <= q_port;
      l_hit  <= s_byp || s_hit;
      l_idx  <= s_byp ? w_idx : s_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
      for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
    end else if (w_en) begin
      ent_v[w_idx] <= 1'b1;
      if (!l_hit)
        rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (w_en) begin
      ent_mac[w_idx]  <= l_mac;
      ent_port[w_idx] <= l_port;
    end
  end

  p_no_dup_r2: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> $onehot0(s_raw));
  p_learn_store_r2: assert property (@(posedge clk) disable iff (rst)
    w_en |=> ent_mac[$past(w_idx)] == $past(l_mac));
  p_learn_port_r11: assert property (@(posedge clk) disable iff (rst)
    w_en |-> l_port < PORT_W'(NPORT));
endmodule

// File: rtl/l2_fwd_decide.sv
module l2_fwd_decide
  import l2fwd_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_RULES   = 8,
  parameter int CFG_AW      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  input  logic [47:0]       hdr_dst_mac,
  input  logic [47:0]       hdr_src_mac,
  input  logic              hdr_tagged,
  input  logic [11:0]       hdr_vid,
  input  logic [1:0]        hdr_in_port,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic              res_valid,
  output logic [2:0]        res_mask,
  output logic              res_flood,
  output logic              res_drop
);
  logic                   rule_en  [NUM_RULES];
  pmask_t                 rule_mem [NUM_RULES];
  vid_t                   rule_vid [NUM_RULES];
  logic [NPORT*NPORT-1:0] perm;
  vid_t                   dflt_vid [NPORT];

  l2fwd_cfg_regs #(.NUM_RULES(NUM_RULES), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rule_en(rule_en), .rule_mem(rule_mem),
    .rule_vid(rule_vid), .perm(perm), .dflt_vid(dflt_vid));

  // stage 1: capture header, resolve VLAN ID and learn eligibility
  logic  v1, grp1, learn1;
  port_t port1;
  mac_t  dst1, src1;
  vid_t  vid1;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= hdr_valid;
  end

  always_ff @(posedge clk) begin
    port1  <= hdr_in_port;
    dst1   <= hdr_dst_mac;
    src1   <= hdr_src_mac;
    grp1   <= hdr_dst_mac[GROUP_BIT];
    learn1 <= (hdr_in_port < PORT_W'(NPORT)) && !hdr_src_mac[GROUP_BIT];
    if (hdr_tagged)                       vid1 <= hdr_vid;
    else if (hdr_in_port < PORT_W'(NPORT)) vid1 <= dflt_vid[hdr_in_port];
    else                                  vid1 <= '0;
  end

  // stage 2: table lookup and VLAN rule
  logic   hit2;
  port_t  hport2;
  pmask_t rule2;
  logic   v2, grp2;
  port_t  port2;

  l2fwd_addr_table #(.ENTRIES(NUM_ENTRIES)) u_tbl (
    .clk(clk), .rst(rst), .q_valid(v1), .q_dst(dst1), .q_src(src1),
    .q_port(port1), .q_learn(learn1), .r_hit(hit2), .r_port(hport2));

  l2fwd_vlan_filter #(.NUM_RULES(NUM_RULES)) u_vlan (
    .clk(clk), .rst(rst), .in_valid(v1), .in_port(port1), .in_vid(vid1),
    .rule_en(rule_en), .rule_mem(rule_mem), .rule_vid(rule_vid),
    .rule_mask(rule2));

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
    port2 <= port1;
    grp2  <= grp1;
  end

  // stage 3: combine base mask with both filters
  pmask_t in_bit, row, base, final_n;
  logic   flood_n;

  always_comb begin
    in_bit  = port_bit(port2);
    row     = '0;
    for (int d = 0; d < NPORT; d++)
      for (int s = 0; s < NPORT; s++)
        if (port2 == PORT_W'(s)) row[d] = perm[s*NPORT + d];
    flood_n = grp2 || !hit2;
    base    = flood_n ? ~in_bit : port_bit(hport2);
    final_n = base & rule2 & row & ~in_bit;
  end

  logic   v3, flood3;
  pmask_t mask3;
  port_t  port3, port4;

  always_ff @(posedge clk) begin
    if (rst) begin
      v3     <= 1'b0;
      mask3  <= '0;
      flood3 <= 1'b0;
    end else begin
      v3     <= v2;
      mask3  <= v2 ? final_n : '0;
      flood3 <= v2 && flood_n;
    end
    port3 <= port2;
  end

  // stage 4: output register
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_mask  <= '0;
      res_flood <= 1'b0;
      res_drop  <= 1'b0;
    end else begin
      res_valid <= v3;
      res_mask  <= v3 ? mask3 : '0;
      res_flood <= v3 && flood3;
      res_drop  <= v3 && (mask3 == '0);
    end
    port4 <= port3;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |-> ##4 res_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (res_mask == '0 && !res_flood && !res_drop));
  p_no_ingress_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_mask & port_bit(port4)) == '0);
  p_bad_port_r11: assert property (@(posedge clk) disable iff (rst)
    v3 && port3 == 2'd3 |-> mask3 == '0);
endmodule

// File: tb/test_l2_fwd_decide.sv
module test_l2_fwd_decide;
  logic        clk = 1'b0;
  logic        rst;
  logic        hdr_valid;
  logic [47:0] hdr_dst_mac, hdr_src_mac;
  logic        hdr_tagged;
  logic [11:0] hdr_vid;
  logic [1:0]  hdr_in_port;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        res_valid, res_flood, res_drop;
  logic [2:0]  res_mask;

  int n_chk = 0;
  int n_fail = 0;

  l2_fwd_decide i_l2_fwd_decide (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_dst_mac(hdr_dst_mac),
    .hdr_src_mac(hdr_src_mac), .hdr_tagged(hdr_tagged), .hdr_vid(hdr_vid),
    .hdr_in_port(hdr_in_port), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .res_valid(res_valid), .res_mask(res_mask),
    .res_flood(res_flood), .res_drop(res_drop));

  always #5 clk = ~clk;

  localparam logic [47:0] MA = 48'h020000000001;
  localparam logic [47:0] MB = 48'h020000000002;
  localparam logic [47:0] MC = 48'h020000000003;
  localparam logic [47:0] MX = 48'h020000000099;
  localparam logic [47:0] MBC = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] MMC = 48'h01005E000001;

  typedef struct packed {
    logic [1:0]  port;
    logic        tag;
    logic [11:0] vid;
    logic [47:0] dst;
    logic [47:0] src;
    logic [2:0]  mask;
    logic        flood;
    logic        drop;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 12'd0,  MB,  MA, 3'b110, 1'b1, 1'b0}, // R4 miss flood, learn A
    '{2'd1, 1'b0, 12'd0,  MA,  MB, 3'b001, 1'b0, 1'b0}, // R3 hit
    '{2'd2, 1'b0, 12'd0,  MA,  MC, 3'b000, 1'b0, 1'b1}, // R8 2->0 denied, R9
    '{2'd0, 1'b0, 12'd0,  MC,  MA, 3'b100, 1'b0, 1'b0}, // R3
    '{2'd2, 1'b0, 12'd0,  MB,  MC, 3'b010, 1'b0, 1'b0}, // R3
    '{2'd2, 1'b0, 12'd0,  MBC, MC, 3'b010, 1'b1, 1'b0}, // R4 broadcast, R8 row
    '{2'd0, 1'b1, 12'd10, MBC, MA, 3'b010, 1'b1, 1'b0}, // R6 member
    '{2'd2, 1'b1, 12'd10, MA,  MC, 3'b000, 1'b0, 1'b1}, // R6 non-member
    '{2'd1, 1'b1, 12'd10, MA,  MB, 3'b001, 1'b0, 1'b0}, // R6 member, hit
    '{2'd0, 1'b0, 12'd0,  MA,  MA, 3'b000, 1'b0, 1'b1}, // R5 hit on ingress
    '{2'd1, 1'b0, 12'd0,  MMC, MB, 3'b101, 1'b1, 1'b0}, // R4 multicast
    '{2'd2, 1'b0, 12'd0,  MB,  MA, 3'b010, 1'b0, 1'b0}, // R2 A moves to 2
    '{2'd1, 1'b0, 12'd0,  MA,  MB, 3'b100, 1'b0, 1'b0}, // R2 refreshed port
    '{2'd3, 1'b0, 12'd0,  MB,  MX, 3'b000, 1'b0, 1'b1}, // R11 bad ingress
    '{2'd0, 1'b0, 12'd0,  MX,  MA, 3'b110, 1'b1, 1'b0}  // R11 X not learned
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic t, input logic [11:0] v,
                       input logic [47:0] d, input logic [47:0] s);
    hdr_valid   = 1'b1;
    hdr_in_port = p;
    hdr_tagged  = t;
    hdr_vid     = v;
    hdr_dst_mac = d;
    hdr_src_mac = s;
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one header, then check result at the fourth edge and quiet afterwards
  task automatic run_one(input string req, input logic [1:0] p, input logic t,
                         input logic [11:0] v, input logic [47:0] d, input logic [47:0] s,
                         input logic [2:0] em, input logic ef, input logic ed);
    drive(p, t, v, d, s);
    @(negedge clk);
    hdr_valid = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk({req, " R1 early"}, 32'(res_valid), 32'd0);
    end
    @(negedge clk);
    chk({req, " R1 valid"}, 32'(res_valid), 32'd1);
    chk({req, " mask"},     32'(res_mask),  32'(em));
    chk({req, " flood"},    32'(res_flood), 32'(ef));
    chk({req, " R9 drop"},  32'(res_drop),  32'(ed));
    @(negedge clk);
    chk({req, " R1 pulse"}, 32'(res_valid), 32'd0);
    chk({req, " R1 idle mask"}, 32'(res_mask), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; hdr_valid = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    hdr_dst_mac = '0; hdr_src_mac = '0; hdr_tagged = 1'b0; hdr_vid = '0; hdr_in_port = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", 32'(res_valid), 32'd0);
    chk("R1 reset mask",  32'(res_mask),  32'd0);
    chk("R9 reset drop",  32'(res_drop),  32'd0);

    // R6 rule 0: enable, members {0,1}, VLAN 10
    cfg_write(5'd0, 16'hB00A);
    // R8 deny port 2 -> port 0 (bit 6)
    cfg_write(5'd16, 16'h01BF);

    for (int i = 0; i < NV; i++)
      run_one($sformatf("vec%0d", i), VECS[i].port, VECS[i].tag, VECS[i].vid,
              VECS[i].dst, VECS[i].src, VECS[i].mask, VECS[i].flood, VECS[i].drop);

    // R7: port 0 default VLAN becomes 10, so rule 0 restricts untagged frames
    cfg_write(5'd17, 16'd10);
    run_one("R7 default vid", 2'd0, 1'b0, 12'd0, MBC, MA, 3'b010, 1'b1, 1'b0);

    // R10: 14 new sources fill slots 3..15 then evict slot 0 (A)
    for (int k = 0; k < 14; k++) begin
      drive(2'd1, 1'b0, 12'd0, MBC, 48'h0A0000000100 + 48'(k));
      @(negedge clk);
      hdr_valid = 1'b0;
      repeat (5) @(negedge clk);
    end
    run_one("R10 evicted A", 2'd1, 1'b0, 12'd0, MA, MB, 3'b101, 1'b1, 1'b0);
    run_one("R10 kept C",    2'd1, 1'b0, 12'd0, MC, MB, 3'b100, 1'b0, 1'b0);

    // R2 / R1: back-to-back, second header looks up the first one's source
    drive(2'd0, 1'b0, 12'd0, MBC, 48'h0E0000000001);
    @(negedge clk);
    drive(2'd1, 1'b0, 12'd0, 48'h0E0000000001, 48'h0F0000000001);
    @(negedge clk);
    hdr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 b2b first valid", 32'(res_valid), 32'd1);
    chk("R4 b2b first mask",  32'(res_mask),  32'b010);
    chk("R4 b2b first flood", 32'(res_flood), 32'd1);
    @(negedge clk);
    chk("R1 b2b second valid", 32'(res_valid), 32'd1);
    chk("R2 b2b second mask",  32'(res_mask),  32'b001);
    chk("R2 b2b second flood", 32'(res_flood), 32'd0);
    @(negedge clk);
    chk("R1 b2b end", 32'(res_valid), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule